// File: doc/BRIEF.md
# ATA Command Strobe Timer

This block times the read/write command strobe of one disk channel that carries several drives, two by default. Each drive has its own 16-bit timing word. A cycle request names a drive. The block then loads that drive's word and drives the strobe high for a programmed active time. It then holds the strobe low for a programmed recovery time and reports the end of the cycle with a one-clock done pulse. The counts are in clocks, so one count is about 30 ns at a 33 MHz clock. One word layout covers PIO modes 0 to 5 and multiword DMA modes 0 to 2 (DMA words 0x0707, 0x0201, 0x0200).

Timing word layout: bits 7:0 hold the recovery clocks minus one, bits 14:8 hold the active clocks minus one, and bit 15 enables the ready-wait. When the wait is enabled and the drive's ready line, after two synchronizer flops, is low at the end of the active phase, the strobe stays high until ready returns. A timing word is sampled when its cycle starts, so software can rewrite it at any time.

Top module: `ata_strobe_timer`

## Requirements
- R1: After reset the strobe, busy and done are low, and every drive's timing word reads back as RESET_WORD (default 0x0707).
- R2: A write with wr_en stores wr_data in the word of drive wr_sel. rd_data always shows the word of drive rd_sel, and writing one drive leaves the others unchanged.
- R3: With bit 15 clear, or with the ready line high, the strobe stays high for exactly bits[14:8]+1 clocks, starting the clock after the request is accepted.
- R4: After the active phase the strobe stays low for exactly bits[7:0]+1 clocks while busy stays high.
- R5: done is high for exactly one clock, in the first clock after recovery, with busy low. busy is high from acceptance until then.
- R6: A request while busy is ignored. After done, busy stays low unless a new request arrives.
- R7: The cycle uses the timing word of the drive named by req_drive when the request is accepted.
- R8: With bit 15 set and the synchronized ready line low at the end of the active phase, the strobe stays high. It falls on the third clock edge after ready rises, and then normal recovery follows.
- R9: With bit 15 clear, a low ready line does not stretch the strobe.
- R10: A write to a drive's word during its cycle does not change that cycle. It applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Timing word write strobe |
| wr_sel | input | 1 | Drive whose word is written |
| wr_data | input | 16 | Timing word to write |
| rd_sel | input | 1 | Drive whose word is read |
| rd_data | output | 16 | Selected timing word |
| req | input | 1 | Cycle request, taken while idle |
| req_drive | input | 1 | Drive for the requested cycle |
| iordy | input | 1 | Asynchronous drive ready line |
| strobe | output | 1 | Command strobe, active high |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The assertions assume that req is held for one clock and that it is not raised in the clock where done is high. They also assume that the ready line only changes between clock edges, which leaves the synchronizer free of metastability. The stimulus drives every input at the falling edge. It pulses req for one clock and waits for done before making the next request. The one exception is the R6 case, where req is raised while busy and dropped again well before recovery ends.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

  localparam int WORD_W = 16;
  localparam int CNT_W  = 8;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ACTIVE,
    PH_WAIT,
    PH_RECOVER
  } phase_e;

  function automatic logic [CNT_W-1:0] active_load(input logic [WORD_W-1:0] w);
    return {1'b0, w[14:8]};
  endfunction

  function automatic logic [CNT_W-1:0] recover_load(input logic [WORD_W-1:0] w);
    return w[7:0];
  endfunction

  function automatic logic wait_enabled(input logic [WORD_W-1:0] w);
    return w[15];
  endfunction

endpackage

// File: rtl/ata_timing_regs.sv
module ata_timing_regs
  import ata_strobe_pkg::*;
#(
  parameter int          NUM_DRIVES = 2,
  parameter logic [15:0] RESET_WORD = 16'h0707,
  localparam int         SEL_W      = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_data,
  input  logic [SEL_W-1:0]  cyc_sel,
  output logic [WORD_W-1:0] cyc_word
);

  logic [WORD_W-1:0] words [NUM_DRIVES];

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
    always_ff @(posedge clk) begin
      if (!rst_n)
        words[d] <= RESET_WORD;
      else if (wr_en && (wr_sel == SEL_W'(d)))
        words[d] <= wr_data;
    end
  end

  assign rd_data  = words[rd_sel];
  assign cyc_word = words[cyc_sel];

endmodule

// File: rtl/ata_ready_sync.sv
module ata_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n)
      chain <= '0;
    else
      chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/ata_strobe_fsm.sv
module ata_strobe_fsm
  import ata_strobe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [WORD_W-1:0] word_in,
  input  logic              ready_s,
  output logic              strobe,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] cur_word,
  output logic              in_wait
);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      cur_word <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (req) begin
            cur_word <= word_in;
            cnt      <= active_load(word_in);
            phase    <= PH_ACTIVE;
          end
        end
        PH_ACTIVE: begin
          if (cnt_zero) begin
            if (wait_enabled(cur_word) && !ready_s) begin
              phase <= PH_WAIT;
            end else begin
              cnt   <= recover_load(cur_word);
              phase <= PH_RECOVER;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_WAIT: begin
          if (ready_s) begin
            cnt   <= recover_load(cur_word);
            phase <= PH_RECOVER;
          end
        end
        PH_RECOVER: begin
          if (cnt_zero) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign strobe  = (phase == PH_ACTIVE) || (phase == PH_WAIT);
  assign busy    = (phase != PH_IDLE);
  assign in_wait = (phase == PH_WAIT);

endmodule

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer
  import ata_strobe_pkg::*;
#(
  parameter int          NUM_DRIVES  = 2,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] RESET_WORD  = 16'h0707,
  localparam int         SEL_W       = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [15:0]      wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [15:0]      rd_data,
  input  logic             req,
  input  logic [SEL_W-1:0] req_drive,
  input  logic             iordy,
  output logic             strobe,
  output logic             busy,
  output logic             done
);

  logic [WORD_W-1:0] sel_word;
  logic [WORD_W-1:0] cur_word;
  logic              ready_s;
  logic              in_wait;

  ata_timing_regs #(
    .NUM_DRIVES (NUM_DRIVES),
    .RESET_WORD (RESET_WORD)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .cyc_sel  (req_drive),
    .cyc_word (sel_word)
  );

  ata_ready_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (iordy),
    .sync_out (ready_s)
  );

  ata_strobe_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .word_in  (sel_word),
    .ready_s  (ready_s),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .cur_word (cur_word),
    .in_wait  (in_wait)
  );

endmodule

// File: rtl/ata_strobe_checker.sv
module ata_strobe_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        strobe,
  input logic        busy,
  input logic        done,
  input logic        in_wait,
  input logic        ready_s,
  input logic [15:0] cur_word
);

  a_r1_strobe_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> busy);

  a_r4_fall_into_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> busy);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !strobe));

  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  a_r8_wait_holds_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> strobe);

  a_r8_wait_leaves_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && ready_s) |=> (!in_wait && !strobe && busy));

  a_r9_wait_only_if_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> cur_word[15]);

  a_r10_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_word));

endmodule

bind ata_strobe_timer ata_strobe_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .strobe   (strobe),
  .busy     (busy),
  .done     (done),
  .in_wait  (in_wait),
  .ready_s  (ready_s),
  .cur_word (cur_word)
);

// File: tb/sim_ata_strobe_timer.sv
module sim_ata_strobe_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [0:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        req = 1'b0;
  logic [0:0]  req_drive = '0;
  logic        iordy = 1'b1;
  logic        strobe, busy, done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ata_strobe_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .req(req), .req_drive(req_drive),
    .iordy(iordy), .strobe(strobe), .busy(busy), .done(done)
  );

  localparam int NVEC = 7;
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 16'h0707}, {1'b1, 16'h0201}, {1'b0, 16'h0200}, {1'b1, 16'h0000},
    {1'b0, 16'h8203}, {1'b1, 16'h0A05}, {1'b0, 16'h7F10}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_word(input int drv, input logic [15:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'(drv); wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_cycle(input int drv, input int hold, input bit mid_en,
                           input logic [15:0] mid_w, input bit poke_req,
                           output int hi, output int lo);
    bit wrote = 0;
    int guard = 0;
    hi = 0; lo = 0;
    @(negedge clk);
    req = 1'b1; req_drive = 1'(drv);
    @(negedge clk);
    req = 1'b0;
    while (!done && guard < 3000) begin
      if (strobe) hi++;
      else if (busy) lo++;
      if (hold >= 0 && hi == hold && !iordy) iordy = 1'b1;
      if (mid_en && hi == 1 && !wrote) begin
        wr_en = 1'b1; wr_sel = 1'(drv); wr_data = mid_w; wrote = 1;
      end else begin
        wr_en = 1'b0;
      end
      req = poke_req && (hi == 2 || hi == 3);
      guard++;
      @(negedge clk);
    end
    wr_en = 1'b0; req = 1'b0;
    check(done && !busy, "R5 done with busy low", int'(busy), 0);
    @(negedge clk);
    check(!done, "R5 done single clock", int'(done), 0);
    check(!busy, "R6 no extra cycle after done", int'(busy), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int hi, lo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!strobe && !busy && !done, "R1 outputs low after reset", int'({strobe, busy, done}), 0);
    for (int d = 0; d < 2; d++) begin
      rd_sel = 1'(d); #1;
      check(rd_data == 16'h0707, "R1 reset word", int'(rd_data), 16'h0707);
    end

    // Table walk: R2, R3, R4, R7
    for (int i = 0; i < NVEC; i++) begin
      int drv = int'(VEC[i][16]);
      logic [15:0] w = VEC[i][15:0];
      logic [15:0] other = 16'h0101;
      write_word(drv, w);
      write_word(1 - drv, other);
      rd_sel = 1'(drv); #1;
      check(rd_data == w, "R2 readback", int'(rd_data), int'(w));
      rd_sel = 1'(1 - drv); #1;
      check(rd_data == other, "R2 other drive", int'(rd_data), int'(other));
      iordy = 1'b1;
      run_cycle(drv, -1, 0, 16'h0, 0, hi, lo);
      check(hi == int'(w[14:8]) + 1, "R3 R7 active clocks", hi, int'(w[14:8]) + 1);
      check(lo == int'(w[7:0]) + 1, "R4 recovery clocks", lo, int'(w[7:0]) + 1);
    end

    // R9: wait disabled, ready low
    write_word(0, 16'h0302);
    iordy = 1'b0;
    repeat (3) @(negedge clk);
    run_cycle(0, -1, 0, 16'h0, 0, hi, lo);
    check(hi == 4, "R9 ready ignored", hi, 4);
    check(lo == 3, "R9 recovery", lo, 3);

    // R8: wait enabled, ready low, release after 10 high clocks
    write_word(1, 16'h8302);
    iordy = 1'b0;
    repeat (3) @(negedge clk);
    run_cycle(1, 10, 0, 16'h0, 0, hi, lo);
    check(hi == 12, "R8 stretched active", hi, 12);
    check(lo == 3, "R8 recovery after wait", lo, 3);
    iordy = 1'b1;
    repeat (3) @(negedge clk);

    // R10: mid-cycle write
    write_word(0, 16'h0403);
    run_cycle(0, -1, 1, 16'h0101, 0, hi, lo);
    check(hi == 5, "R10 current cycle unchanged active", hi, 5);
    check(lo == 4, "R10 current cycle unchanged recovery", lo, 4);
    run_cycle(0, -1, 0, 16'h0, 0, hi, lo);
    check(hi == 2, "R10 next cycle active", hi, 2);
    check(lo == 2, "R10 next cycle recovery", lo, 2);

    // R6: request while busy
    write_word(1, 16'h0504);
    run_cycle(1, -1, 0, 16'h0, 1, hi, lo);
    check(hi == 6, "R6 active unchanged by request", hi, 6);
    check(lo == 5, "R6 recovery unchanged by request", lo, 5);

    // R1 again: reset mid-cycle returns to idle and reset word
    @(negedge clk);
    req = 1'b1; req_drive = 1'b1;
    @(negedge clk);
    req = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_sel = 1'b1; #1;
    check(!strobe && !busy, "R1 reset mid-cycle", int'({strobe, busy}), 0);
    check(rd_data == 16'h0707, "R1 word restored", int'(rd_data), 16'h0707);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule